// File: doc/BRIEF.md
# Dual-Clock Sequential Line Buffer

This block is a byte-wide memory that is accessed in sequence only. It has no address inputs. The write side and the read side each run on their own clock and keep their own location counter. A per-side restart strobe, sampled on that side's clock, sends the counter back to location zero. Each enabled clock edge then moves the counter one location forward, and the counter wraps at the end of the array. The block has no full or empty logic, so the distance between the two counters is whatever the user sets with the restart strobes. A typical use is a programmable delay line, such as one video line that is written on one clock and replayed on another.

The read side has a registered output. A read started on a rising read-clock edge shows its byte after that edge. A flag marks whether the output is being driven. When the flag is low the data bus reads as zero, which stands in for a released bus. The two clocks are fully asynchronous. If a location is read in the same cycle that it is written, the result may be the old byte or the new one.

Top module: `seq_line_buffer`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_en_n` = 0, the byte on `wr_data` is stored at the write counter, and the counter then moves forward one location.
- R2: On a rising `wr_clk` edge with `wr_en_n` = 1, no byte is stored and the write counter holds its value, whatever `wr_data` carries.
- R3: On a rising `rd_clk` edge with `rd_en_n` = 0, the byte at the read counter appears on `rd_data` after that edge, `rd_oe` goes to 1, and the read counter moves forward one location.
- R4: On a rising `rd_clk` edge with `rd_en_n` = 1, the read counter holds its value. After that edge `rd_oe` is 0 and `rd_data` reads 0.
- R5: `wr_ptr_rst` = 1, sampled on a rising `wr_clk` edge, returns the write counter to location 0. If `wr_en_n` = 0 on the same edge, the byte is stored at location 0 and the next write goes to location 1.
- R6: `rd_ptr_rst` = 1, sampled on a rising `rd_clk` edge, returns the read counter to location 0. If `rd_en_n` = 0 on the same edge, location 0 is read and the next read takes location 1.
- R7: Both counters wrap from location DEPTH-1 to location 0. DEPTH defaults to 1024.
- R8: Reads do not consume data. Restarting the read counter and reading again returns the same bytes, as long as nothing has been written in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_ptr_rst | input | 1 | Synchronous restart of the write counter, active high |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DATA_W (8) | Byte to store |
| rd_clk | input | 1 | Read-side clock |
| rd_ptr_rst | input | 1 | Synchronous restart of the read counter, active high |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | DATA_W (8) | Byte read; 0 while `rd_oe` is low |
| rd_oe | output | 1 | High while the output is driven |

## Verification
A write counter that skips a location, or that moves on a disabled edge, does not show up at once. It shows up at the first read that reaches that location, as a byte that belongs to a neighbouring location. A read counter fault shows on the very next enabled read edge, because every read byte is compared in order against a queue of expected bytes. A wrong restart or wrap shows within one or two reads after the strobe or the wrap point. A fault in the output-enable path shows one read-clock edge after the enable changes, as a wrong `rd_oe` value or as non-zero data while the output is released.

// File: rtl/slb_pkg.sv
package slb_pkg;
  parameter int unsigned SLB_BYTE_W = 8;
  parameter int unsigned SLB_DEF_DEPTH = 1024;
endpackage

// File: rtl/slb_ptr.sv
module slb_ptr #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_n,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] ONE  = AW'(1);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          started = 1'b0;

  // effective address of this edge: a restart forces location zero
  always_comb begin
    addr = rst ? '0 : ptr_q;
    if (en_n)                 ptr_d = addr;
    else if (addr == LAST)    ptr_d = '0;
    else                      ptr_d = addr + ONE;
  end

  always_ff @(posedge clk) begin
    ptr_q <= ptr_d;
    if (rst) started <= 1'b1;
  end

  // R2 / R4: disabled edge keeps the counter
  p_ptr_hold_r2_r4: assert property (@(posedge clk) disable iff (!started)
    (!rst && en_n) |=> $stable(ptr_q));
  // R1 / R3: enabled edge steps by one
  p_ptr_step_r1_r3: assert property (@(posedge clk) disable iff (!started)
    (!rst && !en_n && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + ONE);
  // R7: wrap at the last location
  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!started)
    (!rst && !en_n && ptr_q == LAST) |=> ptr_q == '0);
  // R5 / R6: restart alone parks at zero
  p_ptr_restart_r5_r6: assert property (@(posedge clk) disable iff (!started)
    (rst && en_n) |=> ptr_q == '0);
  // R5 / R6: restart with access consumes location zero
  p_ptr_restart_go_r5_r6: assert property (@(posedge clk) disable iff (!started)
    (rst && !en_n) |=> ptr_q == ONE);
endmodule

// File: rtl/slb_mem.sv
module slb_mem #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          wr_act,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_act,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_act) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_act) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/seq_line_buffer.sv
module seq_line_buffer
  import slb_pkg::*;
#(
  parameter int unsigned DEPTH  = SLB_DEF_DEPTH,
  parameter int unsigned DATA_W = SLB_BYTE_W
) (
  input  logic              wr_clk,
  input  logic              wr_ptr_rst,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_ptr_rst,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [AW-1:0]     wr_addr;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rd_q;
  logic              oe_q;
  logic              rd_started = 1'b0;

  slb_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wr_ptr (
    .clk  (wr_clk),
    .rst  (wr_ptr_rst),
    .en_n (wr_en_n),
    .addr (wr_addr)
  );

  slb_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rd_ptr (
    .clk  (rd_clk),
    .rst  (rd_ptr_rst),
    .en_n (rd_en_n),
    .addr (rd_addr)
  );

  slb_mem #(.DEPTH(DEPTH), .DW(DATA_W), .AW(AW)) u_mem (
    .wr_clk  (wr_clk),
    .wr_act  (!wr_en_n),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_clk  (rd_clk),
    .rd_act  (!rd_en_n),
    .rd_addr (rd_addr),
    .rd_q    (rd_q)
  );

  always_ff @(posedge rd_clk) begin
    oe_q <= !rd_en_n;
    if (rd_ptr_rst) rd_started <= 1'b1;
  end

  assign rd_oe   = oe_q;
  assign rd_data = oe_q ? rd_q : '0;

  // R3: an enabled read edge drives the output afterwards
  p_oe_on_r3: assert property (@(posedge rd_clk) disable iff (!rd_started)
    !rd_en_n |=> rd_oe);
  // R4: a disabled read edge releases the output and the bus reads zero
  p_oe_off_r4: assert property (@(posedge rd_clk) disable iff (!rd_started)
    rd_en_n |=> (!rd_oe && rd_data == '0));
endmodule

// File: tb/test_seq_line_buffer.sv
module test_seq_line_buffer;
  localparam int DEPTH = 1024;

  logic       wr_clk = 1'b0;
  logic       rd_clk = 1'b0;
  logic       wr_ptr_rst = 1'b0;
  logic       wr_en_n = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic       rd_ptr_rst = 1'b0;
  logic       rd_en_n = 1'b1;
  logic [7:0] rd_data;
  logic       rd_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit mon_on = 1'b0;
  string cur_req = "R3";

  logic [7:0] exp_mem [DEPTH];
  int wptr_m = 0;
  int rptr_m = 0;
  logic [7:0] expq [$];

  seq_line_buffer #(.DEPTH(DEPTH)) i_seq_line_buffer (
    .wr_clk(wr_clk), .wr_ptr_rst(wr_ptr_rst), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_ptr_rst(rd_ptr_rst), .rd_en_n(rd_en_n),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  always #4 wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #4 rd_clk = ~rd_clk;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge wr_clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  function automatic int step(int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  // driver: write side, with its own model of the write counter
  task automatic wr_cycle(input bit rst, input bit en, input logic [7:0] d);
    int a;
    @(negedge wr_clk);
    wr_ptr_rst = rst;
    wr_en_n = !en;
    wr_data = d;
    a = rst ? 0 : wptr_m;
    if (en) exp_mem[a] = d;
    wptr_m = en ? step(a) : a;
  endtask

  task automatic wr_idle();
    @(negedge wr_clk);
    wr_ptr_rst = 1'b0;
    wr_en_n = 1'b1;
    wr_data = 8'hEE;
  endtask

  // driver: read side, pushes the expected byte for each enabled read
  task automatic rd_cycle(input bit rst, input bit en);
    int a;
    @(negedge rd_clk);
    rd_ptr_rst = rst;
    rd_en_n = !en;
    a = rst ? 0 : rptr_m;
    if (en) expq.push_back(exp_mem[a]);
    rptr_m = en ? step(a) : a;
  endtask

  task automatic rd_drain();
    @(negedge rd_clk);
    rd_ptr_rst = 1'b0;
    rd_en_n = 1'b1;
    while (expq.size() != 0) @(negedge rd_clk);
    repeat (2) @(negedge rd_clk);
  endtask

  // monitor: compares every result after each read-clock edge
  always @(posedge rd_clk) begin
    #2;
    if (mon_on) begin
      checks++;
      if (rd_oe) begin
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL %s rd_oe=1 with no read pending, rd_data=%h expected=released", cur_req, rd_data);
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          if (rd_data !== e) begin
            errors++;
            $display("FAIL %s rd_data=%h expected=%h", cur_req, rd_data, e);
          end
        end
      end else if (rd_data !== 8'h00) begin
        errors++;
        $display("FAIL R4 released rd_data=%h expected=00", rd_data);
      end
    end
  end

  initial begin
    // reset state: both restart strobes with access disabled
    wr_cycle(1'b1, 1'b0, 8'h00);
    wr_idle();
    rd_cycle(1'b1, 1'b0);
    @(negedge rd_clk);
    rd_ptr_rst = 1'b0;
    @(negedge rd_clk);
    checks++;
    if (rd_oe !== 1'b0 || rd_data !== 8'h00) begin
      errors++;
      $display("FAIL R4 reset rd_oe=%b rd_data=%h expected oe=0 data=00", rd_oe, rd_data);
    end
    mon_on = 1'b1;

    // R1, R2: sequential writes with disabled gaps carrying junk
    cur_req = "R1";
    for (int i = 0; i < 10; i++) begin
      if (i == 4 || i == 7) wr_cycle(1'b0, 1'b0, 8'hEE);
      wr_cycle(1'b0, 1'b1, 8'(i * 13 + 5));
    end
    wr_idle();
    repeat (3) @(negedge rd_clk);

    // R3, R6, R4: restart with read on the same edge, stalls in between
    cur_req = "R3";
    rd_cycle(1'b1, 1'b1);
    for (int i = 1; i < 10; i++) begin
      if (i == 3 || i == 6) begin
        rd_cycle(1'b0, 1'b0);
        rd_cycle(1'b0, 1'b0);
      end
      rd_cycle(1'b0, 1'b1);
    end
    rd_drain();

    // R5: restart together with a write stores at zero, next at one
    cur_req = "R5";
    wr_cycle(1'b1, 1'b1, 8'hA1);
    wr_cycle(1'b0, 1'b1, 8'hA2);
    wr_idle();
    repeat (3) @(negedge rd_clk);
    rd_cycle(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) rd_cycle(1'b0, 1'b1);
    rd_drain();

    // R8: replay the same locations without new writes
    cur_req = "R8";
    rd_cycle(1'b1, 1'b1);
    for (int i = 1; i < 6; i++) rd_cycle(1'b0, 1'b1);
    rd_drain();

    // R7: both counters wrap past the last location
    cur_req = "R7";
    wr_cycle(1'b1, 1'b1, 8'h5A);
    for (int j = 1; j < DEPTH + 3; j++) wr_cycle(1'b0, 1'b1, 8'(j) ^ 8'h5A);
    wr_idle();
    repeat (3) @(negedge rd_clk);
    rd_cycle(1'b1, 1'b1);
    for (int j = 1; j < DEPTH + 3; j++) rd_cycle(1'b0, 1'b1);
    rd_drain();

    summary();
  end
endmodule